// File: doc/BRIEF.md
# Integer ALU with Condition Flags and Branch Condition Evaluator

This block is the execute-stage arithmetic core of a small 32-bit processor. It combines two register operands with one of four operations (addition, subtraction, bitwise AND, bitwise XOR) and returns the result combinationally. The same operation also yields three status flags: zero, negative and signed overflow. These flags are captured into a small flag register on a clock edge, but only when the caller raises a set-flags strobe.

A condition evaluator reads the captured flags. It answers whether one of seven conditions holds. A single 4-bit selector serves both conditional jumps and conditional register moves. Selector 0 is always true, which gives an unconditional jump or a plain register-to-register move. The surrounding pipeline owns register writeback and next-PC selection. It uses `result` and `cond_true` as it needs.

Top module: `alucc_top`

## Requirements
- R1: With `alu_fn` = 0, `result` equals `opnd_a + opnd_b` modulo 2^32, in the same cycle.
- R2: With `alu_fn` = 1, `result` equals `opnd_b - opnd_a` modulo 2^32; the B operand is the minuend.
- R3: With `alu_fn` = 2, `result` is the bitwise AND of the operands. With `alu_fn` = 3, it is their bitwise XOR.
- R4: With `alu_fn` from 4 to 15, `result` is zero, and the flag register keeps its value even when `set_cc` is high.
- R5: The `flags` port is packed as bit 2 = zero, bit 1 = sign, bit 0 = overflow. On a rising edge with `set_cc` high and a valid `alu_fn`, zero takes (result == 0) and sign takes result bit 31.
- R6: The captured overflow bit is set when the signed add (R1) or signed subtract (R2) falls outside the 32-bit two's-complement range. AND and XOR always capture overflow as 0.
- R7: While `set_cc` is low, `flags` does not change across clock edges, whatever the other inputs do.
- R8: Reset is synchronous and active low. A rising edge with `rst_n` low sets `flags` to 3'b100 (zero set, sign and overflow clear).
- R9: `cond_true` depends on `cond_fn`, with lt = sign XOR overflow. The codes are: 0 always true; 1 lt OR zero; 2 lt; 3 zero; 4 NOT zero; 5 NOT lt; 6 NOT lt AND NOT zero. Codes 7 to 15 give 0.
- R10: `cond_true` uses the registered flags only. Flags being produced in the current cycle affect it only after the capturing clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; flags are captured on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the flag register |
| alu_fn | input | 4 | Operation select: 0 add, 1 subtract, 2 AND, 3 XOR |
| opnd_a | input | 32 | Operand from the first source register |
| opnd_b | input | 32 | Operand from the second source register |
| set_cc | input | 1 | Capture the flags of the current operation at the next edge |
| cond_fn | input | 4 | Condition select for jumps and conditional moves |
| result | output | 32 | Combinational operation result |
| flags | output | 3 | Registered flags {zero, sign, overflow} |
| cond_true | output | 1 | Selected condition evaluated on the registered flags |

## Verification
The hardest situations to reach are the overflow boundaries. These are sums and differences that cross exactly from 0x7FFFFFFF to 0x80000000 or the other way, and a subtraction whose overflow depends on the sign of B and not of A. The bench sweeps every ordered pair drawn from a set of edge values, including both extreme signed values and their neighbours, through all four operations. It checks all sixteen condition selectors after each capture, so every flag pattern the operations can produce meets every condition. The separation between registered and in-flight flags is checked by sampling `cond_true` in the cycle the strobe is raised, before the capturing edge.

// File: rtl/alucc_pkg.sv
// Package: shared types and constants for the ALU / condition-flag block.
// Assumes a 4-bit function selector for both operations and conditions.
package alucc_pkg;

    localparam int FN_W   = 4;
    localparam int NUM_OP = 4;
    localparam int NUM_CC = 7;

    // Operation codes decoded from the function selector.
    typedef enum logic [FN_W-1:0] {
        OP_ADD = 4'd0,
        OP_SUB = 4'd1,
        OP_AND = 4'd2,
        OP_XOR = 4'd3
    } alu_op_e;

    // Condition codes shared by jumps and conditional moves.
    typedef enum logic [FN_W-1:0] {
        CND_ALWAYS = 4'd0,
        CND_LE     = 4'd1,
        CND_LT     = 4'd2,
        CND_EQ     = 4'd3,
        CND_NE     = 4'd4,
        CND_GE     = 4'd5,
        CND_GT     = 4'd6
    } cond_e;

    // Flag bundle; packed order gives {zero, sign, overflow}.
    typedef struct packed {
        logic zf;
        logic sf;
        logic of;
    } flags_t;

    localparam flags_t FLAGS_RESET = '{zf: 1'b1, sf: 1'b0, of: 1'b0};

endpackage

// File: rtl/alucc_arith.sv
// Module: alucc_arith
// Combinational datapath. It computes the selected operation and the flag
// values that operation would produce. Add and subtract share one adder.
// Subtract forms B + ~A + 1. Assumes two's-complement operands of width W.
module alucc_arith
    import alucc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [FN_W-1:0] fn,
    input  logic [W-1:0]    a,
    input  logic [W-1:0]    b,
    output logic [W-1:0]    res,
    output flags_t          nxt_flags,
    output logic            op_ok
);

    localparam int MSB = W - 1;

    logic         is_sub;
    logic [W-1:0] addend;
    logic [W-1:0] sum;
    logic         sa, sb, sr;
    logic         ovf;

    // Shared adder: conditionally inverts A and injects carry for subtract.
    always_comb begin
        is_sub = (fn == OP_SUB);
        addend = is_sub ? ~a : a;
        sum    = b + addend + {{(W-1){1'b0}}, is_sub};
    end

    // Result mux and overflow rule per operation.
    always_comb begin
        sa    = a[MSB];
        sb    = b[MSB];
        sr    = sum[MSB];
        op_ok = 1'b1;
        ovf   = 1'b0;
        unique case (fn)
            OP_ADD: begin
                res = sum;
                ovf = (sa == sb) && (sr != sa);
            end
            OP_SUB: begin
                res = sum;
                ovf = (sa != sb) && (sr != sb);
            end
            OP_AND: res = a & b;
            OP_XOR: res = a ^ b;
            default: begin
                res   = '0;
                op_ok = 1'b0;
            end
        endcase
    end

    // Flag values derived from the selected result.
    always_comb begin
        nxt_flags.zf = (res == '0);
        nxt_flags.sf = res[MSB];
        nxt_flags.of = ovf;
    end

endmodule

// File: rtl/alucc_flagreg.sv
// Module: alucc_flagreg
// Condition-flag register. It loads new flags on a rising edge when load is
// high. Synchronous active-low reset to zero-set / sign-clear / ovf-clear.
module alucc_flagreg
    import alucc_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   load,
    input  flags_t d,
    output flags_t q
);

    // Capture flags on strobe; reset has priority.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= FLAGS_RESET;
        else if (load)
            q <= d;
    end

    // R8: reset value appears after a reset edge.
    assert_reset_value_R8: assert property (@(posedge clk)
        !rst_n |=> (q == FLAGS_RESET));

    // R7: no load means no change.
    assert_hold_no_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(q));

    // R5: a load captures the datapath's flag values.
    assert_load_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (q == $past(d)));

endmodule

// File: rtl/alucc_cond.sv
// Module: alucc_cond
// Evaluates the seven jump / conditional-move conditions from a flag set.
// Unused selector values evaluate false. Purely combinational.
module alucc_cond
    import alucc_pkg::*;
(
    input  flags_t          cc,
    input  logic [FN_W-1:0] sel,
    output logic            take
);

    logic [NUM_CC-1:0] hit;
    logic              lt;

    // Build all condition outcomes as a vector indexed by condition code.
    always_comb begin
        lt              = cc.sf ^ cc.of;
        hit[CND_ALWAYS] = 1'b1;
        hit[CND_LE]     = lt | cc.zf;
        hit[CND_LT]     = lt;
        hit[CND_EQ]     = cc.zf;
        hit[CND_NE]     = ~cc.zf;
        hit[CND_GE]     = ~lt;
        hit[CND_GT]     = ~lt & ~cc.zf;
    end

    // Select one outcome; out-of-range selectors give false.
    always_comb begin
        if (sel < FN_W'(NUM_CC))
            take = hit[sel[2:0]];
        else
            take = 1'b0;
    end

endmodule

// File: rtl/alucc_top.sv
// Module: alucc_top
// Execute-stage ALU with a registered condition-flag set and a condition
// evaluator. The result is combinational. Flags load on set_cc with a valid
// operation. cond_true reads only the registered flags.
module alucc_top
    import alucc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [FN_W-1:0] alu_fn,
    input  logic [W-1:0]    opnd_a,
    input  logic [W-1:0]    opnd_b,
    input  logic            set_cc,
    input  logic [FN_W-1:0] cond_fn,
    output logic [W-1:0]    result,
    output logic [2:0]      flags,
    output logic            cond_true
);

    flags_t nxt_flags;
    flags_t cur_flags;
    logic   op_ok;
    logic   load;

    alucc_arith #(.W(W)) u_arith (
        .fn        (alu_fn),
        .a         (opnd_a),
        .b         (opnd_b),
        .res       (result),
        .nxt_flags (nxt_flags),
        .op_ok     (op_ok)
    );

    // Only valid operations with the strobe may update the flags.
    always_comb load = set_cc && op_ok;

    alucc_flagreg u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .d     (nxt_flags),
        .q     (cur_flags)
    );

    alucc_cond u_cond (
        .cc   (cur_flags),
        .sel  (cond_fn),
        .take (cond_true)
    );

    // Drive the packed flag port.
    always_comb flags = cur_flags;

    // R4: invalid operations never disturb the flags.
    assert_bad_op_no_update_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_fn > FN_W'(NUM_OP - 1)) |=> $stable(flags));

    // R5: captured zero flag agrees with the result seen at the port.
    assert_zero_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (set_cc && alu_fn < FN_W'(NUM_OP)) |=> (flags[2] == ($past(result) == '0)));

    // R9: selector 0 is always taken.
    assert_always_taken_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_fn == 4'd0) |-> cond_true);

    // R9: unused selectors are never taken.
    assert_unused_cond_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_fn > 4'd6) |-> !cond_true);

    // R6: logic operations capture a clear overflow flag.
    assert_logic_clears_of_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (set_cc && (alu_fn == 4'd2 || alu_fn == 4'd3)) |=> !flags[0]);

endmodule

// File: tb/alucc_top_tb.sv
`timescale 1ns/100ps
module alucc_top_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  alu_fn = '0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic        set_cc = 1'b0;
    logic [3:0]  cond_fn = '0;
    logic [31:0] result;
    logic [2:0]  flags;
    logic        cond_true;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    logic [2:0] mflags;   // model of registered flags {z,s,o}

    always #4 clk = ~clk;   // 125 MHz

    alucc_top u_dut (
        .clk(clk), .rst_n(rst_n), .alu_fn(alu_fn), .opnd_a(opnd_a),
        .opnd_b(opnd_b), .set_cc(set_cc), .cond_fn(cond_fn),
        .result(result), .flags(flags), .cond_true(cond_true)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h (fn=%0d a=%h b=%h cond=%0d)",
                     req, act, exp, alu_fn, opnd_a, opnd_b, cond_fn);
        end
    endtask

    function automatic logic [31:0] pick(input int i);
        case (i)
            0: return 32'h0000_0000;
            1: return 32'h0000_0001;
            2: return 32'hFFFF_FFFF;
            3: return 32'h7FFF_FFFF;
            4: return 32'h8000_0000;
            5: return 32'h8000_0001;
            6: return 32'h1234_5678;
            default: return 32'hF0F0_0F0F;
        endcase
    endfunction

    function automatic logic exp_cond(input logic [2:0] f, input int c);
        logic z, lt;
        z  = f[2];
        lt = f[1] ^ f[0];
        case (c)
            0: return 1'b1;
            1: return lt | z;
            2: return lt;
            3: return z;
            4: return !z;
            5: return !lt;
            6: return !lt && !z;
            default: return 1'b0;
        endcase
    endfunction

    // Sweep all 16 selectors against the model flags (R9), set_cc held low.
    task automatic sweep_cond();
        for (int c = 0; c < 16; c++) begin
            cond_fn = 4'(c);
            #1;
            chk("R9 cond", {31'b0, cond_true}, {31'b0, exp_cond(mflags, c)});
        end
    endtask

    // One operation with capture; checks result, R10 pre-edge, flags after edge.
    task automatic run_op(input int op, input logic [31:0] a, input logic [31:0] b);
        logic [31:0] er;
        longint s;
        logic eo;
        @(negedge clk);
        alu_fn = 4'(op); opnd_a = a; opnd_b = b; set_cc = 1'b1;
        cond_fn = 4'd3;
        #1;
        eo = 1'b0;
        case (op)
            0: begin er = a + b; s = longint'($signed(a)) + longint'($signed(b));
                     eo = (s > 64'sd2147483647) || (s < -64'sd2147483648);
                     chk("R1 add", result, er); end
            1: begin er = b - a; s = longint'($signed(b)) - longint'($signed(a));
                     eo = (s > 64'sd2147483647) || (s < -64'sd2147483648);
                     chk("R2 sub", result, er); end
            2: begin er = a & b; chk("R3 and", result, er); end
            default: begin er = a ^ b; chk("R3 xor", result, er); end
        endcase
        // R10: before the edge, condition still follows the old flags
        chk("R10 pre-edge", {31'b0, cond_true}, {31'b0, mflags[2]});
        @(negedge clk);
        set_cc = 1'b0;
        mflags = {er == 32'd0, er[31], eo};
        chk("R5 flags zs", {29'b0, flags[2:1], 1'b0}, {29'b0, mflags[2:1], 1'b0});
        chk("R6 flag of", {31'b0, flags[0]}, {31'b0, mflags[0]});
        sweep_cond();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        mflags = 3'b100;
        repeat (3) @(negedge clk);
        chk("R8 reset flags", {29'b0, flags}, 32'd4);
        rst_n = 1'b1;
        sweep_cond();

        // Exhaustive sweep over edge-value pairs and all four operations.
        for (int op = 0; op < 4; op++)
            for (int i = 0; i < 8; i++)
                for (int j = 0; j < 8; j++)
                    run_op(op, pick(i), pick(j));

        // R4: invalid codes give zero result and leave flags untouched.
        run_op(0, 32'h7FFF_FFFF, 32'h0000_0001);   // flags = {0,1,1}
        for (int f = 4; f < 16; f++) begin
            @(negedge clk);
            alu_fn = 4'(f); opnd_a = 32'h0; opnd_b = 32'h0; set_cc = 1'b1;
            #1;
            chk("R4 bad op result", result, 32'd0);
            @(negedge clk);
            set_cc = 1'b0;
            chk("R4 bad op flags", {29'b0, flags}, {29'b0, mflags});
        end

        // R7: valid ops with strobe low leave flags alone.
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            alu_fn = 4'(k); opnd_a = 32'h0; opnd_b = 32'h0; set_cc = 1'b0;
            @(negedge clk);
            chk("R7 hold", {29'b0, flags}, {29'b0, mflags});
        end
        sweep_cond();

        // R8: mid-run synchronous reset restores 3'b100.
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R8 sync (no edge yet)", {29'b0, flags}, {29'b0, mflags});
        @(negedge clk);
        rst_n = 1'b1;
        mflags = 3'b100;
        chk("R8 reset flags", {29'b0, flags}, 32'd4);
        sweep_cond();

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule